// File: doc/BRIEF.md
# Programmable 64-bit Countdown Timer

This block is a timer peripheral on a simple 32-bit register bus. A 64-bit start value is written as two words. Setting the enable bit in the control word copies that value into a 64-bit down-counter. The counter then steps down by one on each cycle in which the external `tick` strobe is high. The live count can be read back at any time as two words.

Two modes share the one counter. In reload mode the counter reloads from the start value after it passes zero, which gives a repeating period of start value plus one ticks. In single mode the counter stops at zero after one terminal event. Each terminal event sets a sticky status bit, and software clears it by writing one. A registered interrupt line follows that status bit while the interrupt is unmasked.

Top module: `down_timer64`

## Requirements
- R1: After reset every register reads zero: start words, control, status and count. `irq` and `bus_rdata` are low.
- R2: A read access (`bus_sel`=1, `bus_wr`=0) puts the addressed word on `bus_rdata` one clock later. The start value low and high words are at byte offsets 0x00 and 0x04 and read back what was written. Control is at 0x10 with bit0 enable, bit1 mode and bit2 unmask. Status is at 0x18 with the pending flag in bit0.
- R3: A control write that sets bit0 while the timer is idle copies the 64-bit start value into the counter. While the timer is enabled, each tick lowers a nonzero count by one, and the borrow carries across the 32-bit word boundary.
- R4: A control write with bit0 clear stops the counter. Ticks then leave the count unchanged. Setting bit0 again restarts the count from the start value.
- R5: Mode 0 (reload): a tick at count zero is a terminal event and reloads the start value, so the period is start value plus one ticks. A start value of all ones makes the count read as the inverted number of elapsed ticks.
- R6: Mode 1 (single): the first tick at count zero is a terminal event. The count then holds at zero and no further terminal event occurs until the timer is restarted.
- R7: A terminal event sets the status bit whatever the mask is. Writing 1 to status bit0 clears it, and writing 0 there has no effect. A clear that falls in the same cycle as a terminal event leaves the status bit set.
- R8: `irq` is registered and, one clock later, equals the status bit ANDed with the unmask bit.
- R9: Reads of unmapped offsets return zero, and writes to them are ignored. The two count words at 0x08 and 0x0C are read-only.
- R10: The count words at 0x08 (low) and 0x0C (high) return the live counter, with no snapshot latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the clock after a read access |
| tick | input | 1 | Count strobe from an external tick source |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take for granted that `bus_wr`, `bus_addr` and `bus_wdata` are known whenever `bus_sel` is high, and that reset is held for at least one clock. The bench drives every input at the falling edge and drops `bus_sel` after each single-cycle access. It keeps `tick` low during bus accesses except in the one case where it deliberately makes a clear coincide with a terminal event. It assembles 64-bit counts with a high, low, high read sequence, so a count taken while the counter moves is still consistent.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int unsigned OFS_LOAD = 0;   // start value words at OFS_LOAD + 4*k
  localparam int unsigned OFS_CUR  = 8;   // live count words at OFS_CUR + 4*k
  localparam int unsigned OFS_CTRL = 16;
  localparam int unsigned OFS_STAT = 24;

  typedef enum logic {
    MODE_RELOAD = 1'b0,
    MODE_SINGLE = 1'b1
  } dtmr_mode_e;

  typedef struct packed {
    logic       unmask;
    dtmr_mode_e mode;
    logic       en;
  } dtmr_ctrl_t;
endpackage

// File: rtl/dtmr_regs.sv
module dtmr_regs
  import dtmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              stat_i,
  output logic [CNT_W-1:0]  load_o,
  output dtmr_ctrl_t        ctrl_o,
  output logic              start_o,
  output logic              clr_o
);
  localparam int NW = CNT_W / DATA_W;
  localparam int CW = $bits(dtmr_ctrl_t);

  logic [NW-1:0]     hit_ld, hit_cur;
  logic              hit_ctrl, hit_stat, wr_acc, rd_acc;
  logic [DATA_W-1:0] load_w [NW];
  logic [DATA_W-1:0] rd_mux;
  dtmr_ctrl_t        ctrl_q;

  assign wr_acc   = sel_i & wr_i;
  assign rd_acc   = sel_i & ~wr_i;
  assign hit_ctrl = (addr_i == ADDR_W'(OFS_CTRL));
  assign hit_stat = (addr_i == ADDR_W'(OFS_STAT));

  for (genvar k = 0; k < NW; k++) begin : g_word
    assign hit_ld[k]  = (addr_i == ADDR_W'(OFS_LOAD + 4 * k));
    assign hit_cur[k] = (addr_i == ADDR_W'(OFS_CUR + 4 * k));
    assign load_o[k*DATA_W +: DATA_W] = load_w[k];

    always_ff @(posedge clk) begin
      if (rst)                    load_w[k] <= '0;
      else if (wr_acc && hit_ld[k]) load_w[k] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      ctrl_q <= '0;
    else if (wr_acc && hit_ctrl)  ctrl_q <= dtmr_ctrl_t'(wdata_i[CW-1:0]);
  end

  assign ctrl_o  = ctrl_q;
  assign start_o = wr_acc & hit_ctrl & wdata_i[0] & ~ctrl_q.en;
  assign clr_o   = wr_acc & hit_stat & wdata_i[0];

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NW; k++) begin
      if (hit_ld[k])  rd_mux = load_w[k];
      if (hit_cur[k]) rd_mux = cnt_i[k*DATA_W +: DATA_W];
    end
    if (hit_ctrl) rd_mux = {{(DATA_W-CW){1'b0}}, ctrl_q};
    if (hit_stat) rd_mux = {{(DATA_W-1){1'b0}}, stat_i};
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_o <= '0;
    else if (rd_acc) rdata_o <= rd_mux;
  end

  // R2: read data changes only in response to a read access
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_acc |=> $stable(rdata_o));

  // R9: a write to an unmapped offset leaves the control word untouched
  a_r9_unmapped_wr: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && !hit_ctrl) |=> $stable(ctrl_q));
endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter
  import dtmr_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  dtmr_mode_e       mode_i,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             term_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             fired_q, at_zero, step;

  assign at_zero = (cnt_q == '0);
  assign step    = en_i & tick_i & ~start_i;
  assign term_o  = step & at_zero & ~((mode_i == MODE_SINGLE) & fired_q);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= load_i;
      fired_q <= 1'b0;
    end else if (step) begin
      if (!at_zero)                  cnt_q <= cnt_q - 1'b1;
      else if (mode_i == MODE_RELOAD) cnt_q <= load_i;
      if (term_o && mode_i == MODE_SINGLE) fired_q <= 1'b1;
    end
  end

  // R4: an idle counter does not move
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !start_i) |=> $stable(cnt_q));

  // R3: one step down per tick
  a_r3_decrement: assert property (@(posedge clk) disable iff (rst)
    (step && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R3: start copies the start value
  a_r3_start_load: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (cnt_q == $past(load_i)));

  // R5: reload mode wraps to the start value
  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    (step && at_zero && mode_i == MODE_RELOAD) |=> (cnt_q == $past(load_i)));

  // R6: single mode parks at zero
  a_r6_park: assert property (@(posedge clk) disable iff (rst)
    (en_i && !start_i && at_zero && mode_i == MODE_SINGLE) |=> (cnt_q == '0));
endmodule

// File: rtl/dtmr_irq.sv
module dtmr_irq (
  input  logic clk,
  input  logic rst,
  input  logic term_i,
  input  logic clr_i,
  input  logic unmask_i,
  output logic stat_o,
  output logic irq_o
);
  logic stat_q, irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (term_i)     stat_q <= 1'b1;
      else if (clr_i) stat_q <= 1'b0;
      irq_q <= stat_q & unmask_i;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  // R7: a terminal event always leaves status set, even against a clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    term_i |=> stat_q);

  // R7: status is sticky until cleared
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (stat_q && !clr_i) |=> stat_q);

  // R8: interrupt line follows masked status one clock later
  a_r8_irq_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_q == ($past(stat_q) & $past(unmask_i))));
endmodule

// File: rtl/down_timer64.sv
module down_timer64
  import dtmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] load, cnt;
  dtmr_ctrl_t       ctrl;
  logic             start, clr, term, stat;

  dtmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_regs (
    .clk(clk), .rst(rst), .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata), .cnt_i(cnt), .stat_i(stat),
    .load_o(load), .ctrl_o(ctrl), .start_o(start), .clr_o(clr)
  );

  dtmr_counter #(.CNT_W(CNT_W)) i_counter (
    .clk(clk), .rst(rst), .en_i(ctrl.en), .mode_i(ctrl.mode), .tick_i(tick),
    .start_i(start), .load_i(load), .cnt_o(cnt), .term_o(term)
  );

  dtmr_irq i_irq (
    .clk(clk), .rst(rst), .term_i(term), .clr_i(clr), .unmask_i(ctrl.unmask),
    .stat_o(stat), .irq_o(irq)
  );
endmodule

// File: tb/test_down_timer64.sv
module test_down_timer64;
  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, tick = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int tests = 0, fails = 0;

  localparam logic [4:0] A_LLO = 5'h00, A_LHI = 5'h04, A_CLO = 5'h08,
                         A_CHI = 5'h0C, A_CTL = 5'h10, A_STA = 5'h18;

  always #2 clk = ~clk;

  down_timer64 i_down_timer64 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick), .irq(irq)
  );

  typedef struct packed {
    logic [63:0] load;
    logic        mode;
    logic [31:0] ticks;
    logic [63:0] exp_cnt;
    logic        exp_stat;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{64'd10, 1'b1, 32'd4,  64'd6, 1'b0},                 // R3 single, midway
    '{64'd10, 1'b1, 32'd11, 64'd0, 1'b1},                 // R6 terminal tick
    '{64'd10, 1'b1, 32'd20, 64'd0, 1'b1},                 // R6 parked
    '{64'd5,  1'b0, 32'd6,  64'd5, 1'b1},                 // R5 reload
    '{64'd5,  1'b0, 32'd8,  64'd3, 1'b1},                 // R5 period 6
    '{64'h1_0000_0003, 1'b1, 32'd5, 64'h0_FFFF_FFFE, 1'b0}, // R3 borrow
    '{64'd0,  1'b0, 32'd3,  64'd0, 1'b1},                 // R5 period 1
    '{64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 32'd7, 64'hFFFF_FFFF_FFFF_FFF8, 1'b0}, // R5 inverted
    '{64'd3,  1'b0, 32'd3,  64'd0, 1'b0}                  // R5 at zero, no event yet
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_count(output logic [63:0] v);
    logic [31:0] h1, lo, h2;
    do begin
      bus_read(A_CHI, h1);
      bus_read(A_CLO, lo);
      bus_read(A_CHI, h2);
    end while (h1 != h2);
    v = {h1, lo};
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic arm(input logic [63:0] ld, input logic [2:0] ctl);
    bus_write(A_CTL, 32'd0);
    bus_write(A_STA, 32'd1);
    bus_write(A_LLO, ld[31:0]);
    bus_write(A_LHI, ld[63:32]);
    bus_write(A_CTL, {29'd0, ctl});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1..all actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 irq", irq, 0);
    bus_read(A_CTL, d); chk("R1 ctrl", d, 0);
    bus_read(A_STA, d); chk("R1 status", d, 0);
    read_count(v);      chk("R1 count", v, 0);
    bus_read(A_LHI, d); chk("R1 load hi", d, 0);

    // vector table: R3 R5 R6 R10
    for (int i = 0; i < NV; i++) begin
      arm(VECS[i].load, {1'b0, VECS[i].mode, 1'b1});
      ticks(VECS[i].ticks);
      read_count(v);
      chk($sformatf("R10 vec%0d count", i), v, VECS[i].exp_cnt);
      bus_read(A_STA, d);
      chk($sformatf("R7 vec%0d status", i), d, {31'd0, VECS[i].exp_stat});
      chk($sformatf("R8 vec%0d masked irq", i), irq, 0);
    end

    // R2 read-back of start value and control
    arm(64'h1234_5678_9ABC_DEF0, 3'b011);
    bus_read(A_LLO, d); chk("R2 load lo", d, 32'h9ABC_DEF0);
    bus_read(A_LHI, d); chk("R2 load hi", d, 32'h1234_5678);
    bus_read(A_CTL, d); chk("R2 ctrl", d, 32'd3);

    // R4 disable holds, re-enable restarts
    arm(64'd100, 3'b011);
    ticks(10);
    bus_write(A_CTL, 32'd2);
    ticks(5);
    read_count(v); chk("R4 held", v, 64'd90);
    bus_write(A_CTL, 32'd3);
    read_count(v); chk("R4 restart", v, 64'd100);

    // R6 single shot fires once only
    arm(64'd2, 3'b011);
    ticks(5);
    bus_read(A_STA, d); chk("R6 first event", d, 1);
    bus_write(A_STA, 32'd1);
    ticks(5);
    bus_read(A_STA, d); chk("R6 no second event", d, 0);
    read_count(v);      chk("R6 parked", v, 0);

    // R8 unmasked interrupt, then masking
    arm(64'd2, 3'b111);
    ticks(3);
    bus_read(A_STA, d);
    chk("R8 irq raised", irq, 1);
    bus_write(A_CTL, 32'd3);
    bus_read(A_STA, d);
    chk("R8 irq masked", irq, 0);
    chk("R7 status kept under mask", d, 1);
    bus_write(A_CTL, 32'd7);

    // R7 writing zero does not clear; writing one does
    bus_write(A_STA, 32'd0);
    bus_read(A_STA, d); chk("R7 write zero no effect", d, 1);
    bus_write(A_STA, 32'd1);
    bus_read(A_STA, d); chk("R7 clear", d, 0);
    chk("R8 irq dropped", irq, 0);

    // R7 clear coinciding with a terminal event
    arm(64'd0, 3'b001);
    tick = 1'b1;
    bus_write(A_STA, 32'd1);
    tick = 1'b0;
    bus_read(A_STA, d); chk("R7 set beats clear", d, 1);

    // R9 unmapped offsets and read-only count
    arm(64'd50, 3'b011);
    bus_write(5'h14, 32'hFFFF_FFFF);
    bus_read(5'h14, d); chk("R9 unmapped read", d, 0);
    bus_write(5'h1C, 32'hFFFF_FFFF);
    bus_read(A_CTL, d); chk("R9 ctrl untouched", d, 3);
    bus_write(A_CLO, 32'd7);
    read_count(v); chk("R9 count read-only", v, 64'd50);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule